// File: doc/BRIEF.md
# Page-mode DRAM access controller

This block turns a simple synchronous request port into the pin sequence of an asynchronous page-mode DRAM with a 16-bit data bus. A request carries a 22-bit word address, a write flag, two byte enables and write data. The controller splits the address into row and column halves, which it drives in turn on one multiplexed address bus. It strobes them with RAS# and with two byte-lane CAS# strobes, and it returns read data with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row is served with a CAS-only page cycle. A request to a different row first closes the page with a RAS# precharge, then opens the new row. Every DRAM timing limit is a parameter given in clock cycles: RAS-to-CAS delay, CAS low width, CAS precharge and RAS precharge. An external refresh sequencer raises a request. The controller then finishes the access in flight, closes the page and grants the bus until the request is withdrawn.

Top module: `fpm_ctrl`

## Requirements
- R1: The row half of the request address (`req_addr[21:10]`) is on `dram_addr` when RAS# falls. The column half (`req_addr[9:0]`, zero-extended) is on `dram_addr` when CAS# falls. CAS# is low only while RAS# is low.
- R2: A request whose row equals the open row is served by a CAS-only cycle, and RAS# does not toggle.
- R3: A request to another row raises RAS# for at least T_RP cycles before RAS# falls for the new row. RAS# is low for at least T_RCD cycles before the first CAS# falls.
- R4: `req_be[0]` selects the lower byte lane (DQ 7:0, strobe `dram_casl_n`) and `req_be[1]` selects the upper byte lane (DQ 15:8, strobe `dram_cash_n`). Setting both gives a word access. Read data bytes of lanes that are not enabled return 0.
- R5: Writes are early writes. WE# is low at least one cycle before CAS# falls, both lanes fall on the same edge, and WE# stays stable while CAS# is low.
- R6: Each CAS# low pulse lasts exactly T_CAS cycles. CAS# stays high for at least T_CP cycles between page cycles.
- R7: OE# is low only during a read CAS#, and WE# is high while OE# is low. `rd_data` is captured on the edge where CAS# rises, and `rd_valid` pulses for one cycle. `dq_oe` is high only while a write CAS# is low.
- R8: On `ref_req` the controller completes the current access, closes the page and raises `ref_gnt` with RAS# and both CAS# high. `req_ready` is low while `ref_req` or `ref_gnt` is high. After `ref_req` drops, the next access reopens its row with RAS#.
- R9: After reset RAS#, both CAS#, WE# and OE# are high, and `dq_oe`, `rd_valid` and `ref_gnt` are low. `req_ready` is high when no refresh is requested.
- R10: A read returns the bytes most recently written to that address and lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 22 | Word address, row in bits 21:10, column in 9:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| rd_valid | output | 1 | One-cycle read data strobe |
| ref_req | input | 1 | Refresh sequencer asks for the bus |
| ref_gnt | output | 1 | Bus released to the refresh sequencer |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower byte column strobe, active low |
| dram_cash_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dq_out | output | 16 | Data driven toward the DRAM |
| dq_oe | output | 1 | Enables dq_out onto the DQ bus |
| dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench runs directed sequences first. A word write followed by same-row byte writes and reads tells page hits apart from row reopens. A row change shows the precharge path. A refresh is raised both on an open page and just after a read was accepted, which separates "finish then grant" from a truncated access. Random mixes of reads and writes over four rows and sixteen columns, with all three byte-enable patterns and occasional refreshes, are checked by a pin-level DRAM model that measures every RAS and CAS interval. Reads that leave a lane disabled see junk driven on that lane, so a missing lane mask shows up as a data error.

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_CP  = 1,
  parameter int T_RP  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [1:0]             req_be,
  input  logic [DW-1:0]          req_wdata,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_casl_n,
  output logic                   dram_cash_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DW-1:0]          dq_out,
  output logic                   dq_oe,
  input  logic [DW-1:0]          dq_in
);
  localparam int AW = ROW_W + COL_W;
  localparam int LW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_RCD, S_COLSET, S_CAS, S_CP, S_PRE, S_REF} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row_q;
  logic             page_open, pend;
  logic [AW-1:0]    r_addr;
  logic             r_we;
  logic [1:0]       r_be;
  logic [DW-1:0]    r_wdata;

  wire             acc      = req_valid && req_ready;
  wire [ROW_W-1:0] in_row   = req_addr[AW-1:COL_W];
  wire [ROW_W-1:0] r_row    = r_addr[AW-1:COL_W];
  wire [ROW_W-1:0] r_col    = {{(ROW_W-COL_W){1'b0}}, r_addr[COL_W-1:0]};
  wire [ROW_W-1:0] in_col   = {{(ROW_W-COL_W){1'b0}}, req_addr[COL_W-1:0]};
  wire             hit      = page_open && (in_row == row_q);
  wire [DW-1:0]    lane_msk = {{LW{r_be[1]}}, {LW{r_be[0]}}};

  assign req_ready = (st == S_IDLE || st == S_OPEN) && !ref_req;
  assign dq_out    = r_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      row_q       <= '0;
      page_open   <= 1'b0;
      pend        <= 1'b0;
      r_addr      <= '0;
      r_we        <= 1'b0;
      r_be        <= '0;
      r_wdata     <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      ref_gnt     <= 1'b0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_casl_n <= 1'b1;
      dram_cash_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dq_oe       <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (acc) begin
        r_addr  <= req_addr;
        r_we    <= req_we;
        r_be    <= req_be;
        r_wdata <= req_wdata;
      end
      case (st)
        S_IDLE: begin
          if (ref_req) begin
            ref_gnt <= 1'b1;
            st      <= S_REF;
          end else if (acc) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= in_row;
            row_q      <= in_row;
            page_open  <= 1'b1;
            cnt        <= CNT_W'(T_RCD - 1);
            st         <= S_RCD;
          end
        end
        S_OPEN: begin
          if (ref_req) begin
            dram_ras_n <= 1'b1;
            page_open  <= 1'b0;
            pend       <= 1'b0;
            cnt        <= CNT_W'(T_RP - 1);
            st         <= S_PRE;
          end else if (acc) begin
            if (hit) begin
              dram_addr <= in_col;
              dram_we_n <= !req_we;
              st        <= S_COLSET;
            end else begin
              dram_ras_n <= 1'b1;
              page_open  <= 1'b0;
              pend       <= 1'b1;
              cnt        <= CNT_W'(T_RP - 1);
              st         <= S_PRE;
            end
          end
        end
        S_RCD: begin
          if (cnt == '0) begin
            dram_addr <= r_col;
            dram_we_n <= !r_we;
            st        <= S_COLSET;
          end else cnt <= cnt - 1'b1;
        end
        S_COLSET: begin
          dram_casl_n <= !r_be[0];
          dram_cash_n <= !r_be[1];
          dram_oe_n   <= r_we;
          dq_oe       <= r_we;
          cnt         <= CNT_W'(T_CAS - 1);
          st          <= S_CAS;
        end
        S_CAS: begin
          if (cnt == '0) begin
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_we_n   <= 1'b1;
            dq_oe       <= 1'b0;
            if (!r_we) begin
              rd_data  <= dq_in & lane_msk;
              rd_valid <= 1'b1;
            end
            cnt <= CNT_W'(T_CP - 1);
            st  <= S_CP;
          end else cnt <= cnt - 1'b1;
        end
        S_CP: begin
          if (cnt == '0) st <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (cnt == '0) begin
            if (pend) begin
              dram_ras_n <= 1'b0;
              dram_addr  <= r_row;
              row_q      <= r_row;
              page_open  <= 1'b1;
              pend       <= 1'b0;
              cnt        <= CNT_W'(T_RCD - 1);
              st         <= S_RCD;
            end else if (ref_req) begin
              ref_gnt <= 1'b1;
              st      <= S_REF;
            end else st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter int T_CAS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ref_gnt,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_casl_n,
  input logic dram_cash_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dq_oe
);
  wire cas_any = !dram_casl_n || !dram_cash_n;
  logic [7:0] cas_run;

  always_ff @(posedge clk) begin
    if (!rst_n) cas_run <= '0;
    else if (cas_any) cas_run <= cas_run + 1'b1;
    else cas_run <= '0;
  end

  a_r1_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any |-> !dram_ras_n);

  a_r5_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_casl_n) || $fell(dram_cash_n)) && !dram_we_n) |-> $past(!dram_we_n));

  a_r5_we_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_any && $past(cas_any)) |-> $stable(dram_we_n));

  a_r6_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    cas_run <= 8'(T_CAS));

  a_r7_dq_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!dram_we_n && cas_any));

  a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (dram_we_n && cas_any));

  a_r7_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r8_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && !cas_any && !req_ready));
endmodule

bind fpm_ctrl fpm_ctrl_chk #(.T_CAS(T_CAS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_gnt(ref_gnt),
  .rd_valid(rd_valid), .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n),
  .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
  .dq_oe(dq_oe)
);

// File: tb/fpm_ctrl_tb_top.sv
module fpm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_gnt;
  logic [15:0] rd_data, dq_out, dq_in;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n),
    .dram_cash_n(dram_cash_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // pin-level DRAM model over rows 0..3, columns 0..15
  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic [15:0] exp_q [$];
  logic [11:0] cur_row = '0, last_row = '0;
  logic [9:0]  cur_col = '0, last_col = '0;
  logic [5:0]  midx;
  assign midx = {cur_row[1:0], cur_col[3:0]};
  assign dq_in[7:0]  = (!dram_oe_n && !dram_casl_n) ? mem[midx][7:0]  : 8'h5A;
  assign dq_in[15:8] = (!dram_oe_n && !dram_cash_n) ? mem[midx][15:8] : 8'hC3;

  initial for (int i = 0; i < 64; i++) begin
    mem[i] = 16'(i * 16'h0101) ^ 16'h3C96;
    exp_mem[i] = mem[i];
  end

  int cyc = 0, t_ras_fall = 0, t_ras_rise = 0, t_cas_fall = 0, t_cas_rise = 0;
  int ras_falls = 0, cas_falls = 0;
  logic p_ras = 1'b1, p_we = 1'b1, p_rdv = 1'b0;
  logic [1:0] p_cas = 2'b11;

  always @(negedge clk) begin
    logic [1:0] cas;
    logic [5:0] wi;
    cas = {dram_cash_n, dram_casl_n};
    cyc++;
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        chk(cyc - t_ras_rise >= T_RP, "R3 ras precharge", cyc - t_ras_rise, T_RP);
        cur_row = dram_addr; last_row = dram_addr;
        ras_falls++; t_ras_fall = cyc;
      end
      if (!p_ras && dram_ras_n) t_ras_rise = cyc;
      if (p_cas == 2'b11 && cas != 2'b11) begin
        cur_col = dram_addr[9:0]; last_col = dram_addr[9:0];
        cas_falls++;
        chk(!dram_ras_n, "R1 cas under ras", dram_ras_n, 0);
        chk(cyc - t_ras_fall >= T_RCD, "R3 ras to cas", cyc - t_ras_fall, T_RCD);
        chk(cyc - t_cas_rise >= T_CP, "R6 cas precharge", cyc - t_cas_rise, T_CP);
        if (!dram_we_n) begin
          chk(!p_we, "R5 early write", p_we, 0);
          chk(dq_oe, "R7 write drive", dq_oe, 1);
          wi = {dram_addr[1:0], dram_addr[3:0]};
          wi = {cur_row[1:0], cur_col[3:0]};
          if (!cas[0]) mem[wi][7:0]  = dq_out[7:0];
          if (!cas[1]) mem[wi][15:8] = dq_out[15:8];
        end else chk(!dq_oe, "R7 no drive on read", dq_oe, 0);
        t_cas_fall = cyc;
      end
      if (p_cas != 2'b11 && cas == 2'b11) begin
        chk(cyc - t_cas_fall == T_CAS, "R6 cas width", cyc - t_cas_fall, T_CAS);
        t_cas_rise = cyc;
      end
      if (rd_valid) begin
        chk(!p_rdv, "R7 rd pulse", p_rdv, 0);
        if (exp_q.size() == 0) chk(0, "R10 unexpected read", rd_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R10 R4 read data", rd_data, e);
        end
      end
    end
    p_ras = dram_ras_n; p_cas = cas; p_we = dram_we_n; p_rdv = rd_valid;
  end

  function automatic logic [5:0] idx_of(input logic [21:0] a);
    return {a[11:10], a[3:0]};
  endfunction
  function automatic logic [15:0] msk_of(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic accept_now(input logic [21:0] a, input logic w, input logic [1:0] b, input logic [15:0] d);
    logic [15:0] m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    m = msk_of(b);
    if (w) exp_mem[idx_of(a)] = (exp_mem[idx_of(a)] & ~m) | (d & m);
    else exp_q.push_back(exp_mem[idx_of(a)] & m);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic issue(input logic [21:0] a, input logic w, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    req_addr = a; req_we = w; req_be = b; req_wdata = d; req_valid = 1'b1;
    accept_now(a, w, b, d);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gnt();
    int k = 0;
    while (!ref_gnt && k < 60) begin @(negedge clk); k++; end
    chk(ref_gnt, "R8 grant raised", ref_gnt, 1);
  endtask

  function automatic logic [21:0] mk(input int r, input int c);
    return {12'(r), 10'(c)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int rf, cf, seed;
    logic [31:0] rv;
    seed = 32'd4242;
    rv = $urandom(seed);
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n && dram_oe_n,
        "R9 strobes idle in reset", {dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dq_oe && !rd_valid && !ref_gnt, "R9 flags low", {dq_oe, rd_valid, ref_gnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R9 ready after reset", req_ready, 1);

    issue(mk(1, 2), 1'b1, 2'b11, 16'hBEEF);
    settle(8);
    chk(last_row == 12'd1, "R1 row on pins", last_row, 1);
    chk(last_col == 10'd2, "R1 column on pins", last_col, 2);

    rf = ras_falls;
    issue(mk(1, 3), 1'b1, 2'b01, 16'h1234);
    issue(mk(1, 2), 1'b0, 2'b11, 16'h0);
    issue(mk(1, 3), 1'b0, 2'b10, 16'h0);
    issue(mk(1, 3), 1'b0, 2'b01, 16'h0);
    settle(8);
    chk(ras_falls == rf, "R2 page hit no ras", ras_falls, rf);
    chk(mem[idx_of(mk(1, 3))][7:0] == 8'h34, "R4 lower lane write", mem[idx_of(mk(1, 3))][7:0], 8'h34);

    rf = ras_falls;
    issue(mk(2, 2), 1'b0, 2'b11, 16'h0);
    settle(8);
    chk(ras_falls == rf + 1, "R3 row change reopens", ras_falls, rf + 1);

    ref_req = 1'b1;
    wait_gnt();
    chk(dram_ras_n && dram_casl_n && dram_cash_n, "R8 page closed",
        {dram_ras_n, dram_casl_n, dram_cash_n}, 3'h7);
    chk(!req_ready, "R8 ready low", req_ready, 0);
    cf = cas_falls; rf = ras_falls;
    req_addr = mk(2, 5); req_we = 1'b1; req_be = 2'b11; req_wdata = 16'h5555; req_valid = 1'b1;
    settle(12);
    chk(cas_falls == cf, "R8 request held off", cas_falls, cf);
    ref_req = 1'b0;
    accept_now(mk(2, 5), 1'b1, 2'b11, 16'h5555);
    settle(8);
    chk(ras_falls == rf + 1, "R8 row reopened", ras_falls, rf + 1);

    issue(mk(2, 5), 1'b0, 2'b11, 16'h0);
    ref_req = 1'b1;
    wait_gnt();
    chk(exp_q.size() == 0, "R8 access finished before grant", exp_q.size(), 0);
    settle(3);
    ref_req = 1'b0;

    for (int i = 0; i < 400; i++) begin
      logic [1:0] b;
      b = 2'($urandom_range(1, 3));
      issue(mk($urandom_range(0, 3), $urandom_range(0, 15)), 1'($urandom_range(0, 1)), b,
            16'($urandom()));
      if ($urandom_range(0, 15) == 0) begin
        ref_req = 1'b1;
        wait_gnt();
        settle(2);
        ref_req = 1'b0;
      end
    end
    settle(20);
    chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule